// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Lane SRAM

This block is a synthesizable model of a clocked, pipelined memory with a 32-bit word made of four 8-bit lanes. The address, the command inputs and the write data are all sampled on the rising clock edge. A write is committed to the array at the edge that samples it. A read is held in an input register for one cycle and then passes through an output register, so the read word appears after the second edge.

Three chip-select inputs of mixed polarity must all be in their active state for a cycle to do anything. A low-power sleep input blocks every access. A write can cover the whole word through a global-write input, or selected lanes through a byte-write enable combined with one strobe per lane. An output-enable input with no clock gates the read-valid flag directly.

Top module: `ssram_pipe`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0.
- R2: A read sampled at edge k (selected, not asleep, `gwr_n`=1 and `bwen_n`=1) drives `rdata` with the word at that address and `rvalid`=1 (with `oe_n`=0) after edge k+1.
- R3: When `gwr_n`=0 on a selected edge, all four lanes take `wdata`, whatever `bwen_n` and `lane_we_n` are.
- R4: When `gwr_n`=1 and `bwen_n`=0, only the lanes whose `lane_we_n[i]` is 0 are written. Lane i is bits 8i+7 down to 8i.
- R5: When `gwr_n`=1 and `bwen_n`=1, the cycle is a read. The lane strobes and `wdata` leave the stored word unchanged.
- R6: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination writes nothing and produces no valid read.
- R7: A deselected edge k following a read drops `rvalid` after edge k+1. Back-to-back reads give one word per cycle.
- R8: `oe_n`=1 forces `rvalid` to 0 at once, with no clock edge, and leaves `rdata` unchanged. Clearing `oe_n` restores `rvalid`.
- R9: With `sleep`=1 at an edge, no write is committed and no read is started. A read already in the input register is not delivered if `sleep`=1 at the edge that would deliver it.
- R10: A write at edge k to the address of a read sampled at edge k-1 does not affect that read, which returns the old word. A read sampled at edge k+1 returns the new word.
- R11: With `gwr_n`=1, `bwen_n`=0 and all lane strobes high, the word is unchanged and no read is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*8 | Write data |
| oe_n | input | 1 | Output enable with no clock, active low |
| sleep | input | 1 | Low-power state, active high |
| rdata | output | LANES*8 | Read data from the output register |
| rvalid | output | 1 | Read data valid, gated by `oe_n` |

## Verification
The pipeline can deliver a read from the array in the same cycle that a new write commits to that address. This collision is forced by sampling a read of an address and then, in the next cycle, writing a new word there. The read must return the old word, and a read sampled after the write must return the new one. In a similar way, sleep is raised in the cycle a pending read would be delivered, and `rvalid` must stay low.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } ssram_cmd_e;
endpackage

// File: rtl/ssram_decode.sv
module ssram_decode
  import ssram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             sleep,
  input  logic             gwr_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_we_n,
  output ssram_cmd_e       cmd,
  output logic [LANES-1:0] lane_en
);
  logic selected;
  logic is_write;

  always_comb begin
    selected = !sel1_n && sel2 && !sel3_n && !sleep;
    is_write = !gwr_n || !bwen_n;
    if (!selected)     cmd = CMD_IDLE;
    else if (is_write) cmd = CMD_WRITE;
    else               cmd = CMD_READ;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (cmd != CMD_WRITE) lane_en[i] = 1'b0;
      else if (!gwr_n)      lane_en[i] = 1'b1;
      else                  lane_en[i] = !lane_we_n[i];
    end
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_en[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rword[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;

  always_comb begin
    vld_d  = load;
    data_d = load ? din : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign rdata  = data_q;
  assign rvalid = vld_q && !oe_n;
endmodule

// File: rtl/ssram_pipe.sv
module ssram_pipe
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    gwr_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*8-1:0]      wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*8-1:0]      rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ssram_cmd_e       cmd;
  logic [LANES-1:0] lane_en;

  ssram_decode #(.LANES(LANES)) dec_i (
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .sleep     (sleep),
    .gwr_n     (gwr_n),
    .bwen_n    (bwen_n),
    .lane_we_n (lane_we_n),
    .cmd       (cmd),
    .lane_en   (lane_en)
  );

  // input register stage for reads
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;

  always_comb begin
    rd_d   = (cmd == CMD_READ);
    addr_d = rd_d ? addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd_d;
      addr_q <= addr_d;
    end
  end

  logic [DATA_W-1:0] rword;

  ssram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) arr_i (
    .clk     (clk),
    .lane_en (lane_en),
    .waddr   (addr),
    .wdata   (wdata),
    .raddr   (addr_q),
    .rword   (rword)
  );

  ssram_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (rd_q && !sleep),
    .din    (rword),
    .oe_n   (oe_n),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/ssram_pipe_chk.sv
module ssram_pipe_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel1_n,
  input logic                sel2,
  input logic                sel3_n,
  input logic                gwr_n,
  input logic                bwen_n,
  input logic                oe_n,
  input logic                sleep,
  input logic                rvalid
);
  logic sel_now;
  logic rd_ok;
  assign sel_now = !sel1_n && sel2 && !sel3_n;
  assign rd_ok   = sel_now && !sleep && gwr_n && bwen_n;

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid);

  // R7
  deselect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> ##1 !rvalid);

  // R9
  sleep_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rvalid);

  // R2
  read_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_ok, 2));
endmodule

bind ssram_pipe ssram_pipe_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .sel1_n (sel1_n),
  .sel2   (sel2),
  .sel3_n (sel3_n),
  .gwr_n  (gwr_n),
  .bwen_n (bwen_n),
  .oe_n   (oe_n),
  .sleep  (sleep),
  .rvalid (rvalid)
);

// File: tb/ssram_pipe_tb_top.sv
module ssram_pipe_tb_top;
  localparam int AW = 6;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel1_n, sel2, sel3_n;
  logic          gwr_n, bwen_n;
  logic [3:0]    lane_we_n;
  logic [31:0]   wdata;
  logic          oe_n;
  logic          sleep;
  logic [31:0]   rdata;
  logic          rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  ssram_pipe #(.ADDR_W(AW), .LANES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .gwr_n(gwr_n), .bwen_n(bwen_n), .lane_we_n(lane_we_n),
    .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  typedef struct packed {
    logic        rd;
    logic [5:0]  a;
    logic        gw;
    logic        bw;
    logic [3:0]  ln;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 6'd5, 1'b0, 1'b1, 4'hF, 32'hAABBCCDD, 32'h0,        4'd3},  // R3
    '{1'b1, 6'd5, 1'b1, 1'b1, 4'hF, 32'h0,        32'hAABBCCDD, 4'd3},
    '{1'b0, 6'd5, 1'b1, 1'b0, 4'hA, 32'h11223344, 32'h0,        4'd4},  // R4
    '{1'b1, 6'd5, 1'b1, 1'b1, 4'hF, 32'h0,        32'hAA22CC44, 4'd4},
    '{1'b1, 6'd5, 1'b1, 1'b1, 4'h0, 32'hFFFFFFFF, 32'hAA22CC44, 4'd5},  // R5
    '{1'b0, 6'd9, 1'b0, 1'b0, 4'h0, 32'h01234567, 32'h0,        4'd3},
    '{1'b1, 6'd9, 1'b1, 1'b1, 4'hF, 32'h0,        32'h01234567, 4'd3},
    '{1'b0, 6'd9, 1'b1, 1'b0, 4'hF, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11
    '{1'b1, 6'd9, 1'b1, 1'b1, 4'hF, 32'h0,        32'h01234567, 4'd11},
    '{1'b0, 6'd9, 1'b1, 1'b0, 4'h7, 32'hDE000000, 32'h0,        4'd4},
    '{1'b1, 6'd9, 1'b1, 1'b1, 4'hF, 32'h0,        32'hDE234567, 4'd2}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sel1_n = 1'b1; sel2 = 1'b1; sel3_n = 1'b0;
    gwr_n = 1'b1; bwen_n = 1'b1; lane_we_n = 4'hF; wdata = '0; addr = '0;
  endtask

  task automatic drive(input logic [5:0] a, input logic gw, input logic bw,
                       input logic [3:0] ln, input logic [31:0] d);
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    addr = a; gwr_n = gw; bwen_n = bw; lane_we_n = ln; wdata = d;
  endtask

  task automatic read_word(input logic [5:0] a, input string req, input logic [31:0] exp);
    drive(a, 1'b1, 1'b1, 4'hF, '0);
    step();
    idle();
    step();
    check(req, {31'd0, rvalid}, 32'd1);
    check(req, rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1
    check("R1", {31'd0, rvalid}, 32'd0);
    check("R1", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {31'd0, rvalid}, 32'd0);

    for (int i = 0; i < 11; i++) begin
      drive(VEC[i].a, VEC[i].gw, VEC[i].bw, VEC[i].ln, VEC[i].d);
      step();
      idle();
      step();
      check($sformatf("R%0d", VEC[i].req), {31'd0, rvalid}, {31'd0, VEC[i].rd});
      if (VEC[i].rd) check($sformatf("R%0d", VEC[i].req), rdata, VEC[i].exp);
    end

    // R6: every non-selecting combination
    drive(6'd20, 1'b0, 1'b1, 4'hF, 32'h5555AAAA);
    step();
    idle();
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        drive(6'd20, 1'b0, 1'b0, 4'h0, 32'hFFFF0000 | c);
        {sel1_n, sel2, sel3_n} = c[2:0];
        step();
        idle();
        read_word(6'd20, "R6", 32'h5555AAAA);
        drive(6'd20, 1'b1, 1'b1, 4'hF, '0);
        {sel1_n, sel2, sel3_n} = c[2:0];
        step();
        idle();
        step();
        check("R6", {31'd0, rvalid}, 32'd0);
      end
    end

    // R7: back-to-back reads then a deselect
    drive(6'd5, 1'b1, 1'b1, 4'hF, '0);
    step();
    drive(6'd9, 1'b1, 1'b1, 4'hF, '0);
    step();
    check("R7", {31'd0, rvalid}, 32'd1);
    check("R7", rdata, 32'hAA22CC44);
    idle();
    step();
    check("R7", {31'd0, rvalid}, 32'd1);
    check("R7", rdata, 32'hDE234567);
    step();
    check("R7", {31'd0, rvalid}, 32'd0);

    // R8: output enable gates valid without a clock
    drive(6'd5, 1'b1, 1'b1, 4'hF, '0);
    step();
    idle();
    step();
    oe_n = 1'b1;
    #1;
    check("R8", {31'd0, rvalid}, 32'd0);
    check("R8", rdata, 32'hAA22CC44);
    oe_n = 1'b0;
    #1;
    check("R8", {31'd0, rvalid}, 32'd1);
    step();

    // R9: sleep blocks a write, a read, and a pending delivery
    sleep = 1'b1;
    drive(6'd5, 1'b0, 1'b1, 4'hF, 32'h0);
    step();
    sleep = 1'b0;
    idle();
    read_word(6'd5, "R9", 32'hAA22CC44);
    sleep = 1'b1;
    drive(6'd5, 1'b1, 1'b1, 4'hF, '0);
    step();
    sleep = 1'b0;
    idle();
    step();
    check("R9", {31'd0, rvalid}, 32'd0);
    drive(6'd5, 1'b1, 1'b1, 4'hF, '0);
    step();
    idle();
    sleep = 1'b1;
    step();
    check("R9", {31'd0, rvalid}, 32'd0);
    sleep = 1'b0;
    step();

    // R10: write lands as the earlier read is delivered
    drive(6'd9, 1'b1, 1'b1, 4'hF, '0);
    step();
    drive(6'd9, 1'b0, 1'b1, 4'hF, 32'h0BADF00D);
    step();
    check("R10", {31'd0, rvalid}, 32'd1);
    check("R10", rdata, 32'hDE234567);
    idle();
    read_word(6'd9, "R10", 32'h0BADF00D);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule